// File: doc/BRIEF.md
# Dual-Width DMA Address Generator

This block keeps the running state of one DMA channel while a transfer is under way. A load strobe captures a page number, a 16-bit start offset, a 16-bit count and the channel options. After that, each advance pulse moves the offset forward by one transfer unit and takes one off the remaining count. The 24-bit physical byte address is formed from the latched page and the current offset.

A channel runs in one of two widths. In byte width, every transfer moves one byte and the offset wraps inside a 64K-byte page. In word width, every transfer moves 16 bits. The offset is then scaled by two, the lowest page bit is not used, and the offset wraps inside a 128K-byte page.

The programmed count is one less than the number of transfers. When the last transfer completes, a sticky terminal flag rises. Without autoinitialise, the channel then ignores further advances until it is loaded again. With autoinitialise, the channel restores its start offset and count and keeps running.

Top module: `dma_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, phys_addr_o, cur_cnt_o and tc_o become 0. Until the first load, advance pulses leave all outputs unchanged.
- R2: A load captures base_ofs_i, base_cnt_i, page_i, word_mode_i and auto_init_i. From the following cycle cur_cnt_o equals the captured count and tc_o is 0.
- R3: In byte width (word_mode_i = 0 at load), phys_addr_o[23:16] is the page and phys_addr_o[15:0] is the current offset.
- R4: In word width (word_mode_i = 1 at load), phys_addr_o[0] is 0, phys_addr_o[16:1] is the current offset and phys_addr_o[23:17] is page bits 7:1. Page bit 0 has no effect.
- R5: An accepted advance pulse raises the offset by one and lowers cur_cnt_o by one. Both changes show in the cycle after the pulse.
- R6: The offset wraps from 0xFFFF to 0x0000 without changing the page part of phys_addr_o. This keeps the address inside a 64K page in byte width and inside a 128K page in word width.
- R7: With a loaded count C, tc_o rises in the cycle after the (C+1)-th advance. A count of 0x0000 gives one transfer and 0xFFFF gives 65536. Without autoinitialise, cur_cnt_o then reads 0xFFFF.
- R8: Once tc_o is 1 without autoinitialise, advance pulses change neither phys_addr_o nor cur_cnt_o until the next load.
- R9: With autoinitialise, the terminal advance restores the captured offset and count, sets tc_o, and later advances are still accepted.
- R10: When load and advance occur in the same cycle, the load wins and the advance is dropped.
- R11: page_i, base_ofs_i, base_cnt_i, word_mode_i and auto_init_i have no effect on the outputs unless load_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_i | input | 8 | Page number captured at load |
| base_ofs_i | input | 16 | Start offset captured at load |
| base_cnt_i | input | 16 | Transfer count minus one, captured at load |
| word_mode_i | input | 1 | 1 selects 16-bit transfers, captured at load |
| auto_init_i | input | 1 | 1 enables restore on terminal count, captured at load |
| load_i | input | 1 | Load strobe |
| adv_i | input | 1 | One pulse per completed transfer |
| phys_addr_o | output | 24 | Physical byte address |
| cur_cnt_o | output | 16 | Remaining count minus one |
| tc_o | output | 1 | Sticky terminal-count flag |

## Verification
The bench builds the block with its default widths: an 8-bit page and a 16-bit offset and count. With these widths, a full 65536-transfer run fits within the cycle budget, so the 0xFFFF count corner and the 0x0000 single-transfer corner are both driven directly. Offsets seeded near 0xFFFF bring the page-wrap boundary into reach in both widths. Random loads mixed with dense advance pulses cover load/advance collisions and autoinitialise restarts.

// File: rtl/dma_ag_pkg.sv
// Shared widths and types for the DMA address generator.
package dma_ag_pkg;
    parameter int PAGE_W = 8;
    parameter int OFS_W  = 16;
    parameter int CNT_W  = 16;
    localparam int PHYS_W = PAGE_W + OFS_W;

    // Transfer width latched at load.
    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_WORD = 1'b1
    } xfer_width_e;
endpackage

// File: rtl/dma_ag_ofs_ctr.sv
// Offset counter: holds the current transfer offset.
// Assumes load and step are never both high (the caller gives load priority).
// Wraps modulo 2**OFS_W, so the offset never carries into the page bits.
module dma_ag_ofs_ctr #(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OFS_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [OFS_W-1:0] ofs_o
);
    logic [OFS_W-1:0] ofs_q;

    // Load, step by one unit with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (load_i) begin
            ofs_q <= load_val_i;
        end else if (step_i) begin
            ofs_q <= ofs_q + OFS_W'(1);
        end
    end

    assign ofs_o = ofs_q;
endmodule

// File: rtl/dma_ag_cnt_ctr.sv
// Down counter for the remaining transfers, stored as count minus one.
// last_o flags that the next accepted step is the final transfer.
// Assumes load and step are never both high.
module dma_ag_cnt_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load, or decrement with wrap from zero to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (step_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // The final transfer is the one taken while the count reads zero.
    assign last_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/dma_ag_map.sv
// Combinational mapping of page and offset onto a physical byte address.
// Byte width: {page, offset}. Word width: {page[high:1], offset, 0}.
// Assumes PAGE_W >= 2.
module dma_ag_map
    import dma_ag_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 16,
    localparam int PW    = PAGE_W + OFS_W
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  xfer_width_e       width_i,
    output logic [PW-1:0]     phys_o
);
    logic [PW-1:0] byte_addr;
    logic [PW-1:0] word_addr;

    // Byte view: the page sits directly above the offset.
    assign byte_addr = {page_i, ofs_i};
    // Word view: the offset is scaled by two and page bit 0 is dropped.
    assign word_addr = {page_i[PAGE_W-1:1], ofs_i, 1'b0};

    // Pick the view for the latched width.
    always_comb begin
        phys_o = (width_i == XFER_WORD) ? word_addr : byte_addr;
    end
endmodule

// File: rtl/dma_addr_gen.sv
// Single-channel DMA address generator, top level.
// Captures page, start offset, count and options on load_i, then steps on
// each adv_i. Raises a sticky terminal flag after the final transfer.
// Assumes adv_i is a one-cycle pulse per completed transfer.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int PG_W = dma_ag_pkg::PAGE_W,
    parameter int OF_W = dma_ag_pkg::OFS_W,
    parameter int CN_W = dma_ag_pkg::CNT_W,
    localparam int PA_W = PG_W + OF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PG_W-1:0] page_i,
    input  logic [OF_W-1:0] base_ofs_i,
    input  logic [CN_W-1:0] base_cnt_i,
    input  logic            word_mode_i,
    input  logic            auto_init_i,
    input  logic            load_i,
    input  logic            adv_i,
    output logic [PA_W-1:0] phys_addr_o,
    output logic [CN_W-1:0] cur_cnt_o,
    output logic            tc_o
);
    logic [PG_W-1:0] page_q;
    logic [OF_W-1:0] base_ofs_q;
    logic [CN_W-1:0] base_cnt_q;
    logic            word_q;
    logic            auto_q;
    logic            armed_q;
    logic            tc_q;

    logic            step;
    logic            last;
    logic            term;
    logic            restore;
    logic            ctr_load;
    logic            ctr_step;
    logic [OF_W-1:0] ofs_load_val;
    logic [CN_W-1:0] cnt_load_val;
    logic [OF_W-1:0] cur_ofs;
    xfer_width_e     width;

    // An advance counts only on an armed channel without a competing load.
    assign step     = adv_i && armed_q && !load_i;
    assign term     = step && last;
    assign restore  = term && auto_q;
    assign ctr_load = load_i || restore;
    assign ctr_step = step && !restore;

    // A fresh load takes the ports; an autoinitialise restore takes the shadows.
    always_comb begin
        ofs_load_val = load_i ? base_ofs_i : base_ofs_q;
        cnt_load_val = load_i ? base_cnt_i : base_cnt_q;
    end

    // Shadow registers captured on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q     <= '0;
            base_ofs_q <= '0;
            base_cnt_q <= '0;
            word_q     <= 1'b0;
            auto_q     <= 1'b0;
        end else if (load_i) begin
            page_q     <= page_i;
            base_ofs_q <= base_ofs_i;
            base_cnt_q <= base_cnt_i;
            word_q     <= word_mode_i;
            auto_q     <= auto_init_i;
        end
    end

    // Channel run state and sticky terminal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            tc_q    <= 1'b0;
        end else if (load_i) begin
            armed_q <= 1'b1;
            tc_q    <= 1'b0;
        end else if (term) begin
            armed_q <= auto_q;
            tc_q    <= 1'b1;
        end
    end

    dma_ag_ofs_ctr #(.OFS_W(OF_W)) u_ofs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (ofs_load_val),
        .step_i     (ctr_step),
        .ofs_o      (cur_ofs)
    );

    dma_ag_cnt_ctr #(.CNT_W(CN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (cnt_load_val),
        .step_i     (ctr_step),
        .cnt_o      (cur_cnt_o),
        .last_o     (last)
    );

    assign width = word_q ? XFER_WORD : XFER_BYTE;

    dma_ag_map #(.PAGE_W(PG_W), .OFS_W(OF_W)) u_map (
        .page_i  (page_q),
        .ofs_i   (cur_ofs),
        .width_i (width),
        .phys_o  (phys_addr_o)
    );

    assign tc_o = tc_q;
endmodule

// File: rtl/dma_addr_gen_chk.sv
// Property checker for dma_addr_gen, attached through bind.
// Watches the ports plus the latched width, autoinit and run state.
module dma_addr_gen_chk #(
    parameter int PA_W = 24,
    parameter int CN_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            load_i,
    input logic            adv_i,
    input logic [CN_W-1:0] base_cnt_i,
    input logic [PA_W-1:0] phys_addr_o,
    input logic [CN_W-1:0] cur_cnt_o,
    input logic            tc_o,
    input logic            word_q,
    input logic            auto_q,
    input logic            armed_q
);
    // R2: a load shows its count and clears the flag one cycle later.
    a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cur_cnt_o == $past(base_cnt_i)) && !tc_o);

    // R4: word width never produces an odd byte address.
    a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        word_q |-> (phys_addr_o[0] == 1'b0));

    // R5: an accepted, non-final advance lowers the count by one.
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && armed_q && !load_i && cur_cnt_o != '0) |=>
        (cur_cnt_o == $past(cur_cnt_o) - CN_W'(1)));

    // R6: the upper page bits never change without a load.
    a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(phys_addr_o[PA_W-1:17]));

    // R7: the flag rises only after an advance taken at count zero.
    a_r7_tc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_o) |-> ($past(cur_cnt_o) == '0) && $past(adv_i));

    // R8: a finished channel without autoinit holds its outputs.
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !auto_q && !load_i) |=>
        ($stable(phys_addr_o) && $stable(cur_cnt_o)));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.PA_W(PA_W), .CN_W(CN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .adv_i       (adv_i),
    .base_cnt_i  (base_cnt_i),
    .phys_addr_o (phys_addr_o),
    .cur_cnt_o   (cur_cnt_o),
    .tc_o        (tc_o),
    .word_q      (word_q),
    .auto_q      (auto_q),
    .armed_q     (armed_q)
);

// File: tb/dma_addr_gen_tb_top.sv
// Self-checking bench: directed corners plus seeded random stimulus,
// compared every cycle against a model written from the requirements.
module dma_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  page_i;
    logic [15:0] base_ofs_i;
    logic [15:0] base_cnt_i;
    logic        word_mode_i;
    logic        auto_init_i;
    logic        load_i;
    logic        adv_i;
    logic [23:0] phys_addr_o;
    logic [15:0] cur_cnt_o;
    logic        tc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference state.
    logic [7:0]  m_page;
    logic [15:0] m_ofs, m_cnt, m_bofs, m_bcnt;
    logic        m_word, m_auto, m_armed, m_tc;

    always #10 clk = ~clk;

    dma_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .page_i(page_i), .base_ofs_i(base_ofs_i),
        .base_cnt_i(base_cnt_i), .word_mode_i(word_mode_i),
        .auto_init_i(auto_init_i), .load_i(load_i), .adv_i(adv_i),
        .phys_addr_o(phys_addr_o), .cur_cnt_o(cur_cnt_o), .tc_o(tc_o)
    );

    function automatic logic [23:0] exp_phys(logic [7:0] p, logic [15:0] o, logic w);
        return w ? {p[7:1], o, 1'b0} : {p, o};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, 32'(phys_addr_o), 32'(exp_phys(m_page, m_ofs, m_word)), "phys");
        chk(tag, 32'(cur_cnt_o), 32'(m_cnt), "count");
        chk(tag, 32'(tc_o), 32'(m_tc), "tc");
    endtask

    // Drive one cycle at the current falling edge, advance the model, and
    // compare at the next falling edge.
    task automatic tick(logic ld, logic ad, logic [7:0] pg, logic [15:0] bo,
                        logic [15:0] bc, logic wd, logic au, string tag);
        load_i = ld; adv_i = ad; page_i = pg; base_ofs_i = bo;
        base_cnt_i = bc; word_mode_i = wd; auto_init_i = au;
        if (ld) begin
            m_page = pg; m_bofs = bo; m_bcnt = bc; m_word = wd; m_auto = au;
            m_ofs = bo; m_cnt = bc; m_armed = 1'b1; m_tc = 1'b0;
        end else if (ad && m_armed) begin
            if (m_cnt == 16'h0) begin
                m_tc = 1'b1;
                if (m_auto) begin
                    m_ofs = m_bofs; m_cnt = m_bcnt;
                end else begin
                    m_ofs = m_ofs + 16'd1; m_cnt = 16'hFFFF; m_armed = 1'b0;
                end
            end else begin
                m_ofs = m_ofs + 16'd1; m_cnt = m_cnt - 16'd1;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic adv(int n, string tag);
        for (int i = 0; i < n; i++)
            tick(1'b0, 1'b1, $urandom, $urandom, $urandom, $urandom, $urandom, tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; load_i = 0; adv_i = 0; page_i = 8'hFF; base_ofs_i = '1;
        base_cnt_i = '1; word_mode_i = 0; auto_init_i = 0;
        m_page = 0; m_ofs = 0; m_cnt = 0; m_bofs = 0; m_bcnt = 0;
        m_word = 0; m_auto = 0; m_armed = 0; m_tc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
        // R1: advances before any load do nothing.
        adv(4, "R1");

        // R2 R3: byte load and mapping.
        tick(1, 0, 8'hA5, 16'h1234, 16'd3, 0, 0, "R2");
        chk("R3", 32'(phys_addr_o), 32'h00A51234, "byte map");
        adv(2, "R5");
        // R11: inputs move without a load.
        tick(0, 0, 8'h3C, 16'h9999, 16'h7777, 1, 1, "R11");
        chk("R11", 32'(phys_addr_o), 32'h00A51236, "no-load phys");
        // R7: count 3 gives four transfers.
        adv(1, "R7");
        chk("R7", 32'(tc_o), 32'd0, "tc before last");
        adv(1, "R7");
        chk("R7", 32'(tc_o), 32'd1, "tc after last");
        chk("R7", 32'(cur_cnt_o), 32'h0000FFFF, "count after last");
        // R8: frozen after terminal count.
        adv(3, "R8");
        chk("R8", 32'(phys_addr_o), 32'h00A51238, "frozen phys");

        // R4: word mapping with page bit 0 set.
        tick(1, 0, 8'hA5, 16'h8001, 16'd5, 1, 0, "R4");
        chk("R4", 32'(phys_addr_o), 32'h00A50002, "word map");
        // R6: wrap in both widths.
        tick(1, 0, 8'h12, 16'hFFFF, 16'd9, 0, 0, "R6");
        adv(1, "R6");
        chk("R6", 32'(phys_addr_o), 32'h00120000, "byte wrap");
        tick(1, 0, 8'h13, 16'hFFFF, 16'd9, 1, 0, "R6");
        chk("R6", 32'(phys_addr_o), 32'h0013FFFE, "word top");
        adv(1, "R6");
        chk("R6", 32'(phys_addr_o), 32'h00120000, "word wrap");

        // R7: count zero gives exactly one transfer.
        tick(1, 0, 8'h01, 16'h0040, 16'h0000, 0, 0, "R7");
        adv(1, "R7");
        chk("R7", 32'(tc_o), 32'd1, "single transfer");

        // R9: autoinitialise restores and keeps running.
        tick(1, 0, 8'h20, 16'h0100, 16'd1, 0, 1, "R9");
        adv(2, "R9");
        chk("R9", 32'(phys_addr_o), 32'h00200100, "restored ofs");
        chk("R9", 32'(cur_cnt_o), 32'd1, "restored count");
        adv(1, "R9");
        chk("R9", 32'(phys_addr_o), 32'h00200101, "runs on");

        // R10: load beats a simultaneous advance.
        tick(1, 1, 8'h44, 16'h0010, 16'd7, 0, 0, "R10");
        chk("R10", 32'(cur_cnt_o), 32'd7, "load wins");

        // R7: full 65536-transfer run.
        tick(1, 0, 8'h77, 16'h0000, 16'hFFFF, 1, 0, "R7");
        for (int i = 0; i < 65535; i++) begin
            adv(1, "R7");
        end
        chk("R7", 32'(tc_o), 32'd0, "tc before 65536th");
        adv(1, "R7");
        chk("R7", 32'(tc_o), 32'd1, "tc at 65536th");

        // R5: seeded random mix of loads and advances.
        for (int i = 0; i < 4000; i++) begin
            logic ld;
            logic [15:0] bo, bc;
            ld = ($urandom % 24) == 0;
            bo = ($urandom % 2) ? (16'hFFF0 + 16'($urandom % 16)) : 16'($urandom);
            bc = 16'($urandom % 20);
            tick(ld, ($urandom % 4) != 0, $urandom, bo, bc, $urandom, $urandom, "R5");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule